// File: doc/BRIEF.md
# DDR Framed I/Q Capture Deinterleaver

This block sits behind the receive data pins of a radio transceiver. The transceiver sends one 12-bit word on each edge of a source-synchronous data clock, together with a frame marker. The block captures the word from the rising edge and the word from the falling edge, so it gets one two-word pair per clock cycle. It uses the frame marker to find where each complex sample starts. It then presents whole samples as four parallel words together with a single-cycle strobe. The output clock is the data clock passed straight through, so every output is synchronous to it.

A mode input picks one of two framings. In single-channel mode a sample is two words: I with the marker high, then Q with the marker low. In dual-channel mode a sample is four words in the order I0, Q0, I1, Q1. The marker is high for the first pair and low for the second. A sample is only accepted when the marker goes from low to high. This realigns the block after every idle gap. After reset the block ignores a burst that is already in progress until it has seen the marker low. The mode may only change while the link is idle.

Top module: `iq_ddr_deinterleaver`

## Requirements
- R1: In single-channel mode (`dual_mode`=0), a word I sent on the rising edge of data-clock cycle n with the marker high, followed by a word Q on the falling edge of cycle n with the marker low, gives `out_stb`=1 with `out_i0`=I and `out_q0`=Q. Both are visible after rising edge n+2. This holds only when the marker was low on the word just before I.
- R2: Every strobe in single-channel mode shows `out_i1`=0 and `out_q1`=0.
- R3: In dual-channel mode (`dual_mode`=1), the words I0 and Q0 (marker high on both) in cycle n, followed by I1 and Q1 (marker low on both) in cycle n+1, give one strobe. The strobe carries all four words and is visible after rising edge n+3. The marker must have been low on the word just before I0.
- R4: In dual-channel mode two strobes are never in adjacent cycles. A back-to-back burst of N samples gives exactly N strobes.
- R5: After reset the word before a sample start is treated as having the marker high. The first sample of a burst that is already running when reset is released is therefore not emitted.
- R6: In dual-channel mode a partial sample is discarded without a strobe in three cases: the marker differs between the two words of a pair, a marker-high pair follows another marker-high pair, or a marker-low pair arrives without a stored first pair.
- R7: While the marker stays low (idle), no strobe is issued.
- R8: The four output words change only in a cycle with `out_stb`=1, and all four are loaded from the same sample.
- R9: Synchronous reset drives `out_stb` and all four output words to 0.
- R10: `out_clk` follows the data clock `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source-synchronous data clock; words on both edges |
| rst | input | 1 | Synchronous reset, active high |
| dual_mode | input | 1 | 0 = single-channel framing, 1 = dual-channel framing |
| rx_word | input | 12 | Sample word bus, one word per clock edge |
| rx_frame | input | 1 | Frame marker, sampled on both edges |
| out_clk | output | 1 | Output clock (the data clock) |
| out_stb | output | 1 | One-cycle strobe marking a new sample |
| out_i0 | output | 12 | First-channel I word |
| out_q0 | output | 12 | First-channel Q word |
| out_i1 | output | 12 | Second-channel I word (0 in single-channel mode) |
| out_q1 | output | 12 | Second-channel Q word (0 in single-channel mode) |

## Verification
The bench builds the block with a word width of 12 and with the variant that zeroes the second-channel words. This makes the zero-upper check of single-channel strobes meaningful. The bench keeps a behavioural model of the marker rules and of the pipeline depth (two cycles in single-channel mode, three in dual-channel mode from the first word). It compares every output against that model on every clock. The stimulus includes reset released in the middle of a burst, mode changes during idle gaps, dual-channel patterns with broken marker sequences, and recovery after them.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;
   localparam int DEF_WORD_W = 12;

   // what the assembler does with the pair presented this cycle
   typedef enum logic [2:0] {
      ACT_IDLE  = 3'd0,
      ACT_LOAD  = 3'd1,   // dual: store first I/Q pair
      ACT_EMIT1 = 3'd2,   // single: complete sample
      ACT_EMIT2 = 3'd3,   // dual: second pair completes sample
      ACT_DROP  = 3'd4    // dual: discard partial sample
   } pair_act_t;
endpackage

// File: rtl/iq_ddr_capture.sv
module iq_ddr_capture #(
   parameter int WORD_W = iq_cap_pkg::DEF_WORD_W
) (
   input  logic              clk,
   input  logic [WORD_W-1:0] din,
   input  logic              fin,
   output logic [WORD_W-1:0] pair_hi,
   output logic [WORD_W-1:0] pair_lo,
   output logic              pfr_hi,
   output logic              pfr_lo
);
   localparam int LANE_W = WORD_W + 1;

   logic [LANE_W-1:0] rise_q;
   logic [LANE_W-1:0] fall_q;

   if (WORD_W < 2) begin : g_bad_width
      $error("iq_ddr_capture: WORD_W must be at least 2");
   end

   // falling-edge half of the word pair
   always_ff @(negedge clk) begin
      fall_q <= {fin, din};
   end

   // rising-edge half; pair is formed one edge later so both halves are settled
   always_ff @(posedge clk) begin
      rise_q  <= {fin, din};
      pair_hi <= rise_q[WORD_W-1:0];
      pfr_hi  <= rise_q[WORD_W];
      pair_lo <= fall_q[WORD_W-1:0];
      pfr_lo  <= fall_q[WORD_W];
   end
endmodule

// File: rtl/iq_pair_decoder.sv
module iq_pair_decoder
   import iq_cap_pkg::*;
(
   input  logic      dual,
   input  logic      fr_hi,
   input  logic      fr_lo,
   input  logic      prev_fr,
   input  logic      have_first,
   output pair_act_t act
);
   logic rise_edge;
   assign rise_edge = fr_hi && !prev_fr;

   always_comb begin
      act = ACT_IDLE;
      if (dual) begin
         if (fr_hi && fr_lo && rise_edge)
            act = ACT_LOAD;                               // R3 first pair
         else if (!fr_hi && !fr_lo)
            act = have_first ? ACT_EMIT2 : ACT_IDLE;      // R3 / R7
         else
            act = ACT_DROP;                               // R6
      end else begin
         if (rise_edge && !fr_lo)
            act = ACT_EMIT1;                              // R1
      end
   end
endmodule

// File: rtl/iq_sample_assembler.sv
module iq_sample_assembler
   import iq_cap_pkg::*;
#(
   parameter int WORD_W      = DEF_WORD_W,
   parameter bit ZERO_UNUSED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dual,
   input  logic [WORD_W-1:0] pair_hi,
   input  logic [WORD_W-1:0] pair_lo,
   input  logic              pfr_hi,
   input  logic              pfr_lo,
   output logic              stb,
   output logic [WORD_W-1:0] i0,
   output logic [WORD_W-1:0] q0,
   output logic [WORD_W-1:0] i1,
   output logic [WORD_W-1:0] q1
);
   localparam int BUNDLE_W = 4 * WORD_W;

   pair_act_t         act;
   logic              prev_fr;
   logic              have_first;
   logic [WORD_W-1:0] keep_i;
   logic [WORD_W-1:0] keep_q;
   logic [WORD_W-1:0] single_i1;
   logic [WORD_W-1:0] single_q1;

   iq_pair_decoder u_dec (
      .dual      (dual),
      .fr_hi     (pfr_hi),
      .fr_lo     (pfr_lo),
      .prev_fr   (prev_fr),
      .have_first(have_first),
      .act       (act)
   );

   // variant choice for the unused channel in single-channel mode
   if (ZERO_UNUSED) begin : g_zero_upper
      assign single_i1 = '0;
      assign single_q1 = '0;
   end else begin : g_hold_upper
      assign single_i1 = i1;
      assign single_q1 = q1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_fr    <= 1'b1;          // R5: assume marker high before reset
         have_first <= 1'b0;
         stb        <= 1'b0;          // R9
         i0 <= '0; q0 <= '0; i1 <= '0; q1 <= '0;
         keep_i <= '0; keep_q <= '0;
      end else begin
         prev_fr <= pfr_lo;
         stb     <= 1'b0;
         unique case (act)
            ACT_LOAD: begin
               have_first <= 1'b1;
               keep_i     <= pair_hi;
               keep_q     <= pair_lo;
            end
            ACT_EMIT2: begin          // R8: all four words in one edge
               stb <= 1'b1;
               i0 <= keep_i; q0 <= keep_q; i1 <= pair_hi; q1 <= pair_lo;
               have_first <= 1'b0;
            end
            ACT_EMIT1: begin
               stb <= 1'b1;
               i0 <= pair_hi; q0 <= pair_lo; i1 <= single_i1; q1 <= single_q1;
               have_first <= 1'b0;
            end
            ACT_DROP: have_first <= 1'b0;
            default:  if (!dual) have_first <= 1'b0;
         endcase
      end
   end

   logic [BUNDLE_W-1:0] bundle;
   assign bundle = {i0, q0, i1, q1};

   p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!stb && bundle == '0));

   p_words_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!stb && !$past(rst)) |-> $stable(bundle));

   p_dual_spacing_r4: assert property (@(posedge clk) disable iff (rst)
      (stb && dual) |=> !stb);

   if (ZERO_UNUSED) begin : g_chk_zero
      p_single_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
         (stb && !dual) |-> (i1 == '0 && q1 == '0));
   end
endmodule

// File: rtl/iq_ddr_deinterleaver.sv
module iq_ddr_deinterleaver
   import iq_cap_pkg::*;
#(
   parameter int WORD_W      = DEF_WORD_W,
   parameter bit ZERO_UNUSED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dual_mode,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_frame,
   output logic              out_clk,
   output logic              out_stb,
   output logic [WORD_W-1:0] out_i0,
   output logic [WORD_W-1:0] out_q0,
   output logic [WORD_W-1:0] out_i1,
   output logic [WORD_W-1:0] out_q1
);
   logic [WORD_W-1:0] pair_hi;
   logic [WORD_W-1:0] pair_lo;
   logic              pfr_hi;
   logic              pfr_lo;

   assign out_clk = clk;   // R10

   iq_ddr_capture #(.WORD_W(WORD_W)) u_cap (
      .clk    (clk),
      .din    (rx_word),
      .fin    (rx_frame),
      .pair_hi(pair_hi),
      .pair_lo(pair_lo),
      .pfr_hi (pfr_hi),
      .pfr_lo (pfr_lo)
   );

   iq_sample_assembler #(.WORD_W(WORD_W), .ZERO_UNUSED(ZERO_UNUSED)) u_asm (
      .clk    (clk),
      .rst    (rst),
      .dual   (dual_mode),
      .pair_hi(pair_hi),
      .pair_lo(pair_lo),
      .pfr_hi (pfr_hi),
      .pfr_lo (pfr_lo),
      .stb    (out_stb),
      .i0     (out_i0),
      .q0     (out_q0),
      .i1     (out_i1),
      .q1     (out_q1)
   );
endmodule

// File: tb/sim_iq_ddr_deinterleaver.sv
module sim_iq_ddr_deinterleaver;
   localparam int W    = 12;
   localparam int P    = 10;
   localparam int HALF = P / 2;
   localparam int HN   = 4096;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         dual_mode = 1'b0;
   logic [W-1:0] rx_word = '0;
   logic         rx_frame = 1'b0;
   logic         out_clk, out_stb;
   logic [W-1:0] out_i0, out_q0, out_i1, out_q1;

   int checks = 0, errors = 0, cyc = 0;
   int dut_cnt = 0, mdl_cnt = 0;
   bit done = 1'b0;
   string cur_tag = "R9";

   logic [W-1:0] wq[$];
   bit           fq[$];
   logic [W-1:0] rw[HN], fw[HN];
   bit           rf[HN], ff[HN];

   // model state
   bit           m_prev = 1'b1, m_have = 1'b0;
   logic [W-1:0] m_s0 = '0, m_s1 = '0;
   bit           e_stb = 1'b0;
   logic [W-1:0] e_i0 = '0, e_q0 = '0, e_i1 = '0, e_q1 = '0;
   bit           last_stb = 1'b0;
   logic [W-1:0] last_w[4];

   iq_ddr_deinterleaver u0 (
      .clk(clk), .rst(rst), .dual_mode(dual_mode),
      .rx_word(rx_word), .rx_frame(rx_frame),
      .out_clk(out_clk), .out_stb(out_stb),
      .out_i0(out_i0), .out_q0(out_q0), .out_i1(out_i1), .out_q1(out_q1)
   );

   always #HALF clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic push_pair(input logic [W-1:0] a, input bit fa,
                            input logic [W-1:0] b, input bit fb);
      wq.push_back(a); fq.push_back(fa);
      wq.push_back(b); fq.push_back(fb);
   endtask

   // driver: both words of a pair are popped together before the rising edge
   initial begin
      logic [W-1:0] fall_w;
      bit           fall_f;
      forever begin
         int idx;
         @(negedge clk); #2;
         idx = (cyc + 1) % HN;
         if (wq.size() >= 2) begin
            rx_word = wq.pop_front(); rx_frame = fq.pop_front();
            fall_w  = wq.pop_front(); fall_f   = fq.pop_front();
         end else begin
            rx_word = 12'h5A5; rx_frame = 1'b0;
            fall_w  = 12'h3C3; fall_f   = 1'b0;
         end
         rw[idx] = rx_word; rf[idx] = rx_frame;
         fw[idx] = fall_w;  ff[idx] = fall_f;
         @(posedge clk); #2;
         rx_word = fall_w; rx_frame = fall_f;
      end
   end

   // reference model and per-cycle comparison
   always @(posedge clk) begin
      bit rs, md;
      int n;
      rs = rst; md = dual_mode;
      cyc++;
      #1;
      chk(out_clk === 1'b1, "R10", "out_clk high phase", out_clk, 1);
      if (rs) begin
         m_prev = 1'b1; m_have = 1'b0; e_stb = 1'b0;
         e_i0 = '0; e_q0 = '0; e_i1 = '0; e_q1 = '0;
      end else begin
         logic [W-1:0] a, b;
         bit fa, fb;
         n = (cyc - 2) % HN;
         a = rw[n]; fa = rf[n]; b = fw[n]; fb = ff[n];
         e_stb = 1'b0;
         if (md) begin
            if (fa && fb && !m_prev) begin
               m_have = 1'b1; m_s0 = a; m_s1 = b;
            end else if (!fa && !fb) begin
               if (m_have) begin
                  e_stb = 1'b1; e_i0 = m_s0; e_q0 = m_s1; e_i1 = a; e_q1 = b;
                  m_have = 1'b0;
               end
            end else m_have = 1'b0;
         end else begin
            m_have = 1'b0;
            if (fa && !fb && !m_prev) begin
               e_stb = 1'b1; e_i0 = a; e_q0 = b; e_i1 = '0; e_q1 = '0;
            end
         end
         m_prev = fb;
      end
      if (e_stb) mdl_cnt++;
      if (out_stb) dut_cnt++;
      chk(out_stb === e_stb, cur_tag, "strobe", out_stb, e_stb);
      chk({out_i0, out_q0, out_i1, out_q1} === {e_i0, e_q0, e_i1, e_q1}, cur_tag,
          "words i0q0i1q1", {out_i0, out_q0, out_i1, out_q1}, {e_i0, e_q0, e_i1, e_q1});
      if (out_stb && !md)
         chk(out_i1 == '0 && out_q1 == '0, "R2", "upper words", {out_i1, out_q1}, 0);
      if (out_stb && md)
         chk(!last_stb, "R4", "adjacent dual strobes", last_stb, 0);
      if (!out_stb && !rs && cyc > 1)
         chk({out_i0, out_q0, out_i1, out_q1} === {last_w[0], last_w[1], last_w[2], last_w[3]},
             "R8", "words changed without strobe", {out_i0, out_q0, out_i1, out_q1},
             {last_w[0], last_w[1], last_w[2], last_w[3]});
      last_stb = out_stb;
      last_w[0] = out_i0; last_w[1] = out_q0; last_w[2] = out_i1; last_w[3] = out_q1;
   end

   always @(negedge clk) begin
      #1;
      chk(out_clk === 1'b0, "R10", "out_clk low phase", out_clk, 0);
   end

   task automatic wait_idle();
      wait (wq.size() == 0);
      repeat (6) @(posedge clk);
      #3;
   endtask

   task automatic phase(input string tag);
      @(posedge clk); #3;
      cur_tag = tag; dut_cnt = 0; mdl_cnt = 0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      // R9: reset state
      repeat (2) @(posedge clk);
      #3;
      chk(out_stb === 1'b0, "R9", "strobe in reset", out_stb, 0);
      chk({out_i0, out_q0, out_i1, out_q1} === '0, "R9", "words in reset",
          {out_i0, out_q0, out_i1, out_q1}, 0);

      // R5: burst already running when reset is released
      cur_tag = "R5"; dut_cnt = 0; mdl_cnt = 0;
      for (int k = 0; k < 8; k++) push_pair({4'hA, 8'(k)}, 1, {4'hB, 8'(k)}, 0);
      repeat (3) @(posedge clk);
      #3 rst = 1'b0;
      wait_idle();
      chk(dut_cnt == mdl_cnt && dut_cnt < 8, "R5", "strobes after mid-burst reset", dut_cnt, mdl_cnt);

      // R1: single-channel burst
      phase("R1");
      for (int k = 0; k < 6; k++) push_pair({4'h1, 8'(k + 16)}, 1, {4'h2, 8'(k + 16)}, 0);
      wait_idle();
      chk(dut_cnt == 6, "R1", "single burst strobes", dut_cnt, 6);

      // R7: idle link
      phase("R7");
      repeat (12) @(posedge clk);
      #3;
      chk(dut_cnt == 0, "R7", "idle strobes", dut_cnt, 0);

      // R3 / R4: dual-channel burst
      dual_mode = 1'b1;
      repeat (6) @(posedge clk);
      phase("R3");
      for (int k = 0; k < 5; k++) begin
         push_pair({4'hA, 8'(k)}, 1, {4'hB, 8'(k)}, 1);
         push_pair({4'hC, 8'(k)}, 0, {4'hD, 8'(k)}, 0);
      end
      wait_idle();
      chk(dut_cnt == 5, "R4", "dual burst strobes", dut_cnt, 5);

      // R6: broken dual patterns
      phase("R6");
      push_pair(12'h111, 1, 12'h222, 0);
      push_pair(12'h333, 0, 12'h444, 0);
      wait_idle();
      push_pair(12'h555, 1, 12'h666, 1);
      push_pair(12'h777, 1, 12'h888, 1);
      push_pair(12'h999, 0, 12'hAAA, 0);
      wait_idle();
      chk(dut_cnt == 0, "R6", "strobes on broken patterns", dut_cnt, 0);

      // R3: recovery with a clean dual sample
      phase("R3");
      push_pair(12'hE01, 1, 12'hE02, 1);
      push_pair(12'hE03, 0, 12'hE04, 0);
      wait_idle();
      chk(dut_cnt == 1, "R3", "recovered dual sample", dut_cnt, 1);
      chk(out_i0 == 12'hE01 && out_q1 == 12'hE04, "R3", "recovered words",
          {out_i0, out_q1}, {12'hE01, 12'hE04});

      // R1 / R2: back to single channel
      dual_mode = 1'b0;
      repeat (6) @(posedge clk);
      phase("R1");
      for (int k = 0; k < 3; k++) push_pair({4'h7, 8'(k)}, 1, {4'h8, 8'(k)}, 0);
      wait_idle();
      chk(dut_cnt == 3, "R1", "second single burst", dut_cnt, 3);
      chk(out_i0 == 12'h702 && out_q0 == 12'h802, "R1", "last single words",
          {out_i0, out_q0}, {12'h702, 12'h802});
      chk(out_i1 == '0 && out_q1 == '0, "R2", "upper words after single", {out_i1, out_q1}, 0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(P * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule